// File: doc/BRIEF.md
# Per-Processor Soft Interrupt Register

This block gives one processor a small bank of interrupt state on a 32-bit, word-addressed bus. Its core is a single 32-bit pending word. Software can raise and drop bits in the upper half of that word. It does so through two write-only addresses: one where a written one sets a bit, and one where a written one clears a bit. A hardware event port can also set or clear a single low-order bit, chosen by an interrupt level number.

The upper half of the pending word is shifted down by sixteen places to form a 16-bit vector of interrupt levels. Logic outside this block merges that vector with routed system interrupts before it reaches the processor's priority logic. Bit 16 can never be written, so level 0 of the vector always stays low.

On the clear address there is one special case. A one written in bit 14 also clears bit 31, which is the soft request for level 15. All state changes take effect on the clock edge that samples the write strobe or the hardware event. Reads are combinational.

Top module: `sirq_cpu_reg`

## Requirements
- R1: A synchronous, active-high reset leaves the pending word at zero. The level vector is then all zero.
- R2: A read at word address 0 returns the full 32-bit pending word, including the low bits set by hardware.
- R3: A read at any word address other than 0 (1, 2 or 3) returns zero.
- R4: A write to word address 2 ORs the written data, masked to bits 31..17, into the pending word at the next clock edge. Bits 16..0 of the written data are discarded.
- R5: A write to word address 1 clears every pending bit in 31..17 whose written data bit is one, at the next clock edge. Bits 16..0 of the pending word are unaffected.
- R6: In a write to word address 1, a one in data bit 14 also clears pending bit 31, whether or not data bit 31 is set.
- R7: Level output L (L = 1..15) equals pending bit L+16 at all times. Level output 0 is always low.
- R8: When the hardware event is valid, pending bit N, where N is the level number on the event port, is set if the set/clear flag is 1 and cleared if it is 0. The change lands at the next clock edge. An event with level number 0 has no effect.
- R9: Writes to word addresses 0 and 3 leave the pending word unchanged.
- R10: A bus write and a hardware event in the same cycle both take effect at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| hw_valid | input | 1 | Hardware event strobe |
| hw_set | input | 1 | 1 sets the selected bit, 0 clears it |
| hw_level | input | 4 | Level number that selects the pending bit |
| level_out | output | 16 | Per-level interrupt request vector |

## Verification
The set path is tried with full-word data and with sparse patterns. These show that bits 16..0 are masked off while every soft bit is accepted. The clear path is tried three ways: with data bit 14 alone, with bit 31 alone, and with both. These separate the alias rule from an ordinary clear and from a missing one. A walking one across bits 17..31 confirms that each level output maps to its own pending bit with no shift error. Hardware events at levels 0, 1 and 15, with and without a bus write in the same cycle, tell the low-half path apart from the software path.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    localparam int SIRQ_DATA_W  = 32;
    localparam int SIRQ_LEVELS  = 16;
    localparam int SIRQ_ADDR_W  = 2;

    // Word addresses; software depends on these values
    localparam int unsigned WA_PENDING = 0;
    localparam int unsigned WA_CLEAR   = 1;
    localparam int unsigned WA_SET     = 2;

    // Clear-data bit that also drops the top soft bit
    localparam int unsigned ALIAS_SRC_BIT = 14;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2
    } bus_op_e;

    typedef struct packed {
        logic       valid;
        logic       set;
        logic [$clog2(SIRQ_LEVELS)-1:0] level;
    } hw_evt_t;

endpackage

// File: rtl/sirq_decode.sv
module sirq_decode
    import sirq_pkg::*;
#(
    parameter int ADDR_W = SIRQ_ADDR_W
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output bus_op_e           op
);

    always_comb begin
        op = OP_NONE;
        if (wr) begin
            if (addr == ADDR_W'(WA_SET))
                op = OP_SET;
            else if (addr == ADDR_W'(WA_CLEAR))
                op = OP_CLR;
        end
    end

endmodule

// File: rtl/sirq_next.sv
module sirq_next
    import sirq_pkg::*;
#(
    parameter int DATA_W = SIRQ_DATA_W,
    parameter int LEVELS = SIRQ_LEVELS
) (
    input  logic [DATA_W-1:0] pend_q,
    input  bus_op_e           op,
    input  logic [DATA_W-1:0] wdata,
    input  hw_evt_t           hw,
    output logic [DATA_W-1:0] pend_d
);

    localparam int SOFT_LO   = LEVELS + 1;
    localparam int ALIAS_DST = DATA_W - 1;
    localparam logic [DATA_W-1:0] SOFT_MASK =
        {{(DATA_W - SOFT_LO){1'b1}}, {SOFT_LO{1'b0}}};

    logic [DATA_W-1:0] clr_bits;
    logic [DATA_W-1:0] set_bits;
    logic [DATA_W-1:0] sw_next;

    always_comb begin
        clr_bits = wdata;
        if (wdata[ALIAS_SRC_BIT])
            clr_bits[ALIAS_DST] = 1'b1;
        clr_bits = clr_bits & SOFT_MASK;
        set_bits = wdata & SOFT_MASK;
    end

    always_comb begin
        unique case (op)
            OP_SET:  sw_next = pend_q | set_bits;
            OP_CLR:  sw_next = pend_q & ~clr_bits;
            default: sw_next = pend_q;
        endcase
    end

    // Hardware touches only bits 1..LEVELS-1, software only the upper
    // soft bits, so both updates compose without priority.
    always_comb begin
        pend_d = sw_next;
        if (hw.valid && (hw.level != '0))
            pend_d[hw.level] = hw.set;
    end

endmodule

// File: rtl/sirq_cpu_reg.sv
module sirq_cpu_reg
    import sirq_pkg::*;
#(
    parameter int DATA_W = SIRQ_DATA_W,
    parameter int LEVELS = SIRQ_LEVELS,
    parameter int ADDR_W = SIRQ_ADDR_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic                       hw_valid,
    input  logic                       hw_set,
    input  logic [$clog2(LEVELS)-1:0]  hw_level,
    output logic [LEVELS-1:0]          level_out
);

    logic [DATA_W-1:0] pend_q;
    logic [DATA_W-1:0] pend_d;
    bus_op_e           op;
    hw_evt_t           hw;

    assign hw = '{valid: hw_valid, set: hw_set, level: hw_level};

    sirq_decode #(.ADDR_W(ADDR_W)) u_decode (
        .wr   (bus_wr),
        .addr (bus_addr),
        .op   (op)
    );

    sirq_next #(.DATA_W(DATA_W), .LEVELS(LEVELS)) u_next (
        .pend_q (pend_q),
        .op     (op),
        .wdata  (bus_wdata),
        .hw     (hw),
        .pend_d (pend_d)
    );

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= '0;
        else
            pend_q <= pend_d;
    end

    assign bus_rdata = (bus_addr == ADDR_W'(WA_PENDING)) ? pend_q : '0;

    assign level_out[0] = 1'b0;
    for (genvar l = 1; l < LEVELS; l++) begin : g_lvl
        assign level_out[l] = pend_q[l + LEVELS];
    end

endmodule

// File: rtl/sirq_cpu_reg_chk.sv
module sirq_cpu_reg_chk
    import sirq_pkg::*;
#(
    parameter int DATA_W = SIRQ_DATA_W,
    parameter int LEVELS = SIRQ_LEVELS,
    parameter int ADDR_W = SIRQ_ADDR_W
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      bus_wr,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [DATA_W-1:0]         bus_wdata,
    input logic [DATA_W-1:0]         bus_rdata,
    input logic                      hw_valid,
    input logic                      hw_set,
    input logic [$clog2(LEVELS)-1:0] hw_level,
    input logic [LEVELS-1:0]         level_out,
    input logic [DATA_W-1:0]         pend_q
);

    localparam int SOFT_LO = LEVELS + 1;
    localparam logic [DATA_W-1:0] SMASK =
        {{(DATA_W - SOFT_LO){1'b1}}, {SOFT_LO{1'b0}}};

    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (pend_q == '0));

    p_read_matches_level_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(WA_PENDING)) |->
            (bus_rdata[DATA_W-1:SOFT_LO] == level_out[LEVELS-1:1]));

    p_level0_low_r7: assert property (@(posedge clk) disable iff (rst)
        !level_out[0]);

    p_set_lands_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(WA_SET)) |=>
            ((pend_q & $past(bus_wdata & SMASK)) == $past(bus_wdata & SMASK)));

    p_clear_lands_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(WA_CLEAR)) |=>
            ((pend_q & $past(bus_wdata & SMASK)) == '0));

    p_clear_alias_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(WA_CLEAR) && bus_wdata[ALIAS_SRC_BIT]) |=>
            !pend_q[DATA_W-1]);

    p_low_half_kept_r5: assert property (@(posedge clk) disable iff (rst)
        !hw_valid |=> $stable(pend_q[LEVELS:0]));

    p_hw_set_r8: assert property (@(posedge clk) disable iff (rst)
        (hw_valid && hw_set && hw_level != '0) |=> pend_q[$past(hw_level)]);

    p_hw_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (hw_valid && !hw_set && hw_level != '0) |=> !pend_q[$past(hw_level)]);

    p_idle_addr_r9: assert property (@(posedge clk) disable iff (rst)
        (!hw_valid && (!bus_wr || bus_addr == ADDR_W'(WA_PENDING)
                       || bus_addr == ADDR_W'(3))) |=> $stable(pend_q));

endmodule

bind sirq_cpu_reg sirq_cpu_reg_chk #(
    .DATA_W(DATA_W), .LEVELS(LEVELS), .ADDR_W(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .hw_valid  (hw_valid),
    .hw_set    (hw_set),
    .hw_level  (hw_level),
    .level_out (level_out),
    .pend_q    (pend_q)
);

// File: tb/test_sirq_cpu_reg.sv
module test_sirq_cpu_reg;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        string       tag;
        logic [31:0] exp_rd;
        logic [15:0] exp_lv;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        hw_valid = 1'b0;
    logic        hw_set = 1'b0;
    logic [3:0]  hw_level = '0;
    logic [15:0] level_out;

    int          n_cmp = 0;
    int          n_bad = 0;
    logic [31:0] model = '0;
    exp_item_t   sb[$];
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sirq_cpu_reg i_sirq_cpu_reg (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_valid(hw_valid),
        .hw_set(hw_set), .hw_level(hw_level), .level_out(level_out)
    );

    // Bench's own model of the requirements
    function automatic logic [31:0] apply_sw(logic [31:0] m, logic [1:0] a,
                                             logic [31:0] d);
        logic [31:0] c;
        if (a == 2'd2) return m | (d & 32'hFFFE_0000);
        if (a == 2'd1) begin
            c = d;
            if (d[14]) c[31] = 1'b1;
            return m & ~(c & 32'hFFFE_0000);
        end
        return m;
    endfunction

    task automatic step(input bit wr, input logic [1:0] a, input logic [31:0] d,
                        input bit hv, input bit hs, input logic [3:0] hl);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        hw_valid = hv; hw_set = hs; hw_level = hl;
        @(negedge clk);
        bus_wr = 1'b0; hw_valid = 1'b0;
        if (wr) model = apply_sw(model, a, d);
        if (hv && hl != 4'd0) model[hl] = hs;
    endtask

    task automatic expect_rd(input logic [1:0] a, input string tag);
        exp_item_t it;
        bus_addr = a;
        it.tag    = tag;
        it.exp_rd = (a == 2'd0) ? model : 32'h0;
        it.exp_lv = {model[31:17], 1'b0};
        sb.push_back(it);
        @(negedge clk);
    endtask

    // Monitor: compares queued expectations a little after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                exp_item_t it;
                it = sb.pop_front();
                n_cmp++;
                if (bus_rdata !== it.exp_rd || level_out !== it.exp_lv) begin
                    n_bad++;
                    $display("FAIL %s: rdata=%h level=%h expected rdata=%h level=%h",
                             it.tag, bus_rdata, level_out, it.exp_rd, it.exp_lv);
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        model = '0;
        expect_rd(2'd0, "R1 reset state");
        rst = 1'b0;
        expect_rd(2'd0, "R1 after release");

        // R4: full-word set, low half masked away
        step(1, 2'd2, 32'hFFFF_FFFF, 0, 0, 0);
        expect_rd(2'd0, "R4 full set");
        // R3: other addresses read zero
        expect_rd(2'd1, "R3 read addr1");
        expect_rd(2'd2, "R3 read addr2");
        expect_rd(2'd3, "R3 read addr3");

        // R5: ordinary clear, sparse pattern
        step(1, 2'd1, 32'h0A02_0001, 0, 0, 0);
        expect_rd(2'd0, "R5 sparse clear");
        // R6: alias bit 14 clears bit 31
        step(1, 2'd1, 32'h0000_4000, 0, 0, 0);
        expect_rd(2'd0, "R6 alias clear");
        // R5: bit 31 directly
        step(1, 2'd2, 32'h8000_0000, 0, 0, 0);
        step(1, 2'd1, 32'h8000_0000, 0, 0, 0);
        expect_rd(2'd0, "R5 clear bit31");
        // R6: both together
        step(1, 2'd2, 32'h8000_0000, 0, 0, 0);
        step(1, 2'd1, 32'h8000_4000, 0, 0, 0);
        expect_rd(2'd0, "R6 alias with bit31");

        // R9: writes to addr 0 and 3 ignored
        step(1, 2'd0, 32'hFFFF_FFFF, 0, 0, 0);
        expect_rd(2'd0, "R9 write addr0 ignored");
        step(1, 2'd3, 32'h0000_0000, 0, 0, 0);
        step(1, 2'd3, 32'hFFFF_FFFF, 0, 0, 0);
        expect_rd(2'd0, "R9 write addr3 ignored");

        // R8: hardware events, including level 0
        step(0, 2'd0, 0, 1, 1, 4'd5);
        expect_rd(2'd0, "R8 hw set 5 R2 low bits read");
        step(0, 2'd0, 0, 1, 1, 4'd15);
        step(0, 2'd0, 0, 1, 1, 4'd1);
        expect_rd(2'd0, "R8 hw set 15 and 1");
        step(0, 2'd0, 0, 1, 1, 4'd0);
        expect_rd(2'd0, "R8 level 0 ignored");
        step(0, 2'd0, 0, 1, 0, 4'd5);
        expect_rd(2'd0, "R8 hw clear 5");
        // R5: soft clear leaves hw bits
        step(1, 2'd1, 32'hFFFF_FFFF, 0, 0, 0);
        expect_rd(2'd0, "R5 clear keeps low bits");

        // R10: bus write and hw event in same cycle
        step(1, 2'd2, 32'h0004_0000, 1, 1, 4'd9);
        expect_rd(2'd0, "R10 set + hw set");
        step(1, 2'd1, 32'h0004_0000, 1, 0, 4'd15);
        expect_rd(2'd0, "R10 clear + hw clear");

        // R7: walking one across soft bits
        for (int b = 17; b < 32; b++) begin
            step(1, 2'd2, 32'h1 << b, 0, 0, 0);
            expect_rd(2'd0, $sformatf("R7 walk bit %0d", b));
            step(1, 2'd1, 32'h1 << b, 0, 0, 0);
        end
        expect_rd(2'd0, "R7 walk cleared");

        // R1: reset mid-run
        step(1, 2'd2, 32'hF0F0_0000, 1, 1, 4'd3);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        model = '0;
        expect_rd(2'd0, "R1 mid-run reset");
        rst = 1'b0;
        @(negedge clk);

        #2;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule